// File: doc/BRIEF.md
# External Interrupt Line Controller

This block gathers many external interrupt pins into one interrupt request. The pins are grouped 32 to a 32-bit word, called a port. For each line, software chooses level or edge detection, the active polarity and a mask. Software can also force a line pending by writing a software trigger. Each pin passes through a two-stage synchronizer. An edge that matches the line's polarity sets a sticky pending flag, which software clears by writing an acknowledge. In level mode, the pending state follows the synchronized pin directly.

Every control field has one read address and two write-only aliases. One alias sets bits and the other clears bits, so software can change single lines without a read-modify-write sequence. A per-line domain-enable word gates every line from the combined output. The domain-enable word resets to zero, so nothing reaches the output until software writes ones into it. Because each line detects only one edge direction, software can emulate dual-edge detection: it flips the polarity and raises a software trigger when it sees the pin change during service.

Top module: `extint_ctrl`

## Requirements
- R1: After reset, every mask bit reads 1 (all lines disabled). Sensitivity, polarity, software trigger, domain enable and status all read 0, and `irq_out` is 0.
- R2: Line n is bit n mod 32 of port n/32. The address is bus_addr = {group[4:0], port[3:0], 2'b00}. Groups: status 0, acknowledge 1, mask 2, mask-set 3, mask-clear 4, sensitivity 5, sensitivity-set 6, sensitivity-clear 7, soft 8, soft-set 9, soft-clear 10, polarity 12, polarity-set 13, polarity-clear 14, domain enable 16. The write-only groups (1, 3, 4, 6, 7, 9, 10, 13, 14) read as 0.
- R3: Writing the mask-set alias sets the mask bits that are 1 in the data. Writing the mask-clear alias clears them. All other mask bits keep their values. A write to the mask read address (group 2) changes nothing.
- R4: The sensitivity, polarity and soft fields are changed only through their set and clear aliases, with the same per-bit behaviour as the mask.
- R5: With sensitivity 0 (edge mode), a line's status bit becomes 1 on a synchronized rising edge when polarity is 1, and on a falling edge when polarity is 0. It stays 1 after the pin returns. The opposite edge direction does not set it.
- R6: Writing 1 to an acknowledge bit clears that line's latched edge status. Acknowledge bits written as 0 leave status unchanged.
- R7: With sensitivity 1 (level mode), a line's status bit equals 1 exactly while the synchronized pin equals its polarity bit.
- R8: A set soft bit makes that line's status read 1 whatever the pin does. An acknowledge does not remove it. It stays until it is cleared through the soft-clear alias.
- R9: `irq_out` is the OR, over all lines, of status AND NOT mask AND domain enable.
- R10: The domain-enable word (group 16) is written directly and resets to 0. While all domain-enable bits are 0, `irq_out` stays 0.
- R11: Changing a line's polarity while its pin is steady never sets its edge status.
- R12: A level-mode pin change that lands before clock edge A is not yet visible after edge A. It reaches status and `irq_out` after the next edge B, two edges in total.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | 11 | Byte address {group, port, 2'b00} |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| ext_pin | input | NUM_PORTS*32 | Asynchronous external interrupt pins |
| irq_out | output | 1 | Combined interrupt request |

## Verification
On every cycle, the embedded assertions check four things. A mask-set write always leaves the set bits at 1. An acknowledged line with no coincident edge ends up cleared. A soft bit never falls without a clear write. An edge flag never rises unless the synchronized pin changed, which covers polarity changes. They also check that the output stays low while the domain enable is all zero. The bench scenarios cover what a single cycle cannot show. They confirm that edge and level detection match polarity over sequences of pin patterns. They confirm that every one of the 64 lines maps to the right port and bit and gates the output correctly. They also confirm the two-edge synchronizer latency and the read-only nature of the read addresses.

// File: rtl/extint_pkg.sv
package extint_pkg;
  localparam int LINE_W = 32;
  localparam int GRP_W  = 5;
  localparam int PIDX_W = 4;

  typedef enum logic [GRP_W-1:0] {
    GRP_STAT     = 5'd0,
    GRP_ACK      = 5'd1,
    GRP_MASK     = 5'd2,
    GRP_MASK_SET = 5'd3,
    GRP_MASK_CLR = 5'd4,
    GRP_SENS     = 5'd5,
    GRP_SENS_SET = 5'd6,
    GRP_SENS_CLR = 5'd7,
    GRP_SOFT     = 5'd8,
    GRP_SOFT_SET = 5'd9,
    GRP_SOFT_CLR = 5'd10,
    GRP_POL      = 5'd12,
    GRP_POL_SET  = 5'd13,
    GRP_POL_CLR  = 5'd14,
    GRP_DOM      = 5'd16
  } grp_e;
endpackage

// File: rtl/extint_sync.sv
module extint_sync #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] meta_q;
  logic [WIDTH-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/extint_port.sv
module extint_port #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin_i,
  input  logic [W-1:0] ack_i,
  input  logic [W-1:0] mset_i,
  input  logic [W-1:0] mclr_i,
  input  logic [W-1:0] sset_i,
  input  logic [W-1:0] sclr_i,
  input  logic [W-1:0] pset_i,
  input  logic [W-1:0] pclr_i,
  input  logic [W-1:0] fset_i,
  input  logic [W-1:0] fclr_i,
  input  logic         dom_we_i,
  input  logic [W-1:0] dom_d_i,
  output logic [W-1:0] stat_o,
  output logic [W-1:0] mask_o,
  output logic [W-1:0] sens_o,
  output logic [W-1:0] pol_o,
  output logic [W-1:0] soft_o,
  output logic [W-1:0] dom_o,
  output logic         req_o
);
  logic [W-1:0] mask_q, mask_n;
  logic [W-1:0] sens_q, sens_n;
  logic [W-1:0] pol_q,  pol_n;
  logic [W-1:0] soft_q, soft_n;
  logic [W-1:0] lat_q,  lat_n;
  logic [W-1:0] dom_q;
  logic [W-1:0] pin_d_q;
  logic [W-1:0] rise, fall, evt, lvl;

  always_comb begin
    mask_n = (mask_q | mset_i) & ~mclr_i;
    sens_n = (sens_q | sset_i) & ~sclr_i;
    pol_n  = (pol_q  | pset_i) & ~pclr_i;
    soft_n = (soft_q | fset_i) & ~fclr_i;
    rise   = pin_i & ~pin_d_q;
    fall   = ~pin_i & pin_d_q;
    evt    = ~sens_q & ((pol_q & rise) | (~pol_q & fall));
    lat_n  = ((lat_q & ~ack_i) | evt) & ~sens_q;
    lvl    = sens_q & ~(pin_i ^ pol_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q  <= '1;
      sens_q  <= '0;
      pol_q   <= '0;
      soft_q  <= '0;
      lat_q   <= '0;
      pin_d_q <= '0;
    end else begin
      mask_q  <= mask_n;
      sens_q  <= sens_n;
      pol_q   <= pol_n;
      soft_q  <= soft_n;
      lat_q   <= lat_n;
      pin_d_q <= pin_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dom_q <= '0;
    end else if (dom_we_i) begin
      dom_q <= dom_d_i;
    end
  end

  assign stat_o = lvl | lat_q | soft_q;
  assign mask_o = mask_q;
  assign sens_o = sens_q;
  assign pol_o  = pol_q;
  assign soft_o = soft_q;
  assign dom_o  = dom_q;
  assign req_o  = |(stat_o & ~mask_q & dom_q);

  // R3
  mask_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((mask_q & $past(mset_i & ~mclr_i)) == $past(mset_i & ~mclr_i)));

  // R6
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((lat_q & $past(ack_i & ~evt)) == '0));

  // R8
  soft_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(soft_q & ~fclr_i) & ~soft_q) == '0));

  // R11
  no_spurious_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((lat_q & ~$past(lat_q) & ~$past(pin_i ^ pin_d_q)) == '0));
endmodule

// File: rtl/extint_ctrl.sv
module extint_ctrl
  import extint_pkg::*;
#(
  parameter int NUM_PORTS = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        bus_wr,
  input  logic [10:0]                 bus_addr,
  input  logic [31:0]                 bus_wdata,
  output logic [31:0]                 bus_rdata,
  input  logic [NUM_PORTS*LINE_W-1:0] ext_pin,
  output logic                        irq_out
);
  localparam int LINES = NUM_PORTS * LINE_W;

  logic [LINES-1:0]  pin_s;
  logic [GRP_W-1:0]  grp;
  logic [PIDX_W-1:0] pidx;
  logic              aligned;
  logic [LINE_W-1:0] stat_a [NUM_PORTS];
  logic [LINE_W-1:0] mask_a [NUM_PORTS];
  logic [LINE_W-1:0] sens_a [NUM_PORTS];
  logic [LINE_W-1:0] pol_a  [NUM_PORTS];
  logic [LINE_W-1:0] soft_a [NUM_PORTS];
  logic [LINE_W-1:0] dom_a  [NUM_PORTS];
  logic [NUM_PORTS-1:0] req;
  logic              any_dom;

  assign grp     = bus_addr[10:6];
  assign pidx    = bus_addr[5:2];
  assign aligned = (bus_addr[1:0] == 2'b00);

  extint_sync #(.WIDTH(LINES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (ext_pin),
    .q_o   (pin_s)
  );

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    logic              hit;
    logic [LINE_W-1:0] wd;
    assign hit = bus_wr && aligned && (pidx == PIDX_W'(p));
    assign wd  = bus_wdata;

    extint_port #(.W(LINE_W)) u_port (
      .clk      (clk),
      .rst_n    (rst_n),
      .pin_i    (pin_s[p*LINE_W +: LINE_W]),
      .ack_i    ((hit && grp == GRP_ACK)      ? wd : '0),
      .mset_i   ((hit && grp == GRP_MASK_SET) ? wd : '0),
      .mclr_i   ((hit && grp == GRP_MASK_CLR) ? wd : '0),
      .sset_i   ((hit && grp == GRP_SENS_SET) ? wd : '0),
      .sclr_i   ((hit && grp == GRP_SENS_CLR) ? wd : '0),
      .pset_i   ((hit && grp == GRP_POL_SET)  ? wd : '0),
      .pclr_i   ((hit && grp == GRP_POL_CLR)  ? wd : '0),
      .fset_i   ((hit && grp == GRP_SOFT_SET) ? wd : '0),
      .fclr_i   ((hit && grp == GRP_SOFT_CLR) ? wd : '0),
      .dom_we_i (hit && grp == GRP_DOM),
      .dom_d_i  (wd),
      .stat_o   (stat_a[p]),
      .mask_o   (mask_a[p]),
      .sens_o   (sens_a[p]),
      .pol_o    (pol_a[p]),
      .soft_o   (soft_a[p]),
      .dom_o    (dom_a[p]),
      .req_o    (req[p])
    );
  end

  always_comb begin
    bus_rdata = '0;
    any_dom   = 1'b0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      any_dom = any_dom | (|dom_a[p]);
      if (aligned && pidx == PIDX_W'(p)) begin
        case (grp)
          GRP_STAT: bus_rdata = stat_a[p];
          GRP_MASK: bus_rdata = mask_a[p];
          GRP_SENS: bus_rdata = sens_a[p];
          GRP_SOFT: bus_rdata = soft_a[p];
          GRP_POL:  bus_rdata = pol_a[p];
          GRP_DOM:  bus_rdata = dom_a[p];
          default:  bus_rdata = '0;
        endcase
      end
    end
  end

  assign irq_out = |req;

  // R10
  dom_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !any_dom |-> !irq_out);
endmodule

// File: tb/extint_ctrl_bench.sv
`timescale 1ns/1ps
module extint_ctrl_bench;
  import extint_pkg::*;
  localparam int NP = 2;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_wr;
  logic [10:0] bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [63:0] ext_pin;
  logic        irq_out;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [31:0] m_mask [NP];
  logic [31:0] m_sens [NP];
  logic [31:0] m_pol  [NP];
  logic [31:0] m_soft [NP];
  logic [31:0] m_dom  [NP];
  logic [31:0] m_lat  [NP];

  always #4 clk = ~clk;

  extint_ctrl #(.NUM_PORTS(NP)) u_extint_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ext_pin(ext_pin),
    .irq_out(irq_out)
  );

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", r, act, exp);
    end
  endtask

  task automatic do_wr(input grp_e g, input int p, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = {g, 4'(p), 2'b00}; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
    case (g)
      GRP_ACK:      m_lat[p]  &= ~d;
      GRP_MASK_SET: m_mask[p] |= d;
      GRP_MASK_CLR: m_mask[p] &= ~d;
      GRP_SENS_SET: begin m_sens[p] |= d; m_lat[p] &= ~m_sens[p]; end
      GRP_SENS_CLR: m_sens[p] &= ~d;
      GRP_POL_SET:  m_pol[p]  |= d;
      GRP_POL_CLR:  m_pol[p]  &= ~d;
      GRP_SOFT_SET: m_soft[p] |= d;
      GRP_SOFT_CLR: m_soft[p] &= ~d;
      GRP_DOM:      m_dom[p]  = d;
      default: ;
    endcase
  endtask

  task automatic rd(input grp_e g, input int p, output logic [31:0] d);
    @(negedge clk);
    bus_addr = {g, 4'(p), 2'b00};
    #1;
    d = bus_rdata;
  endtask

  function automatic logic [31:0] exp_stat(input int p);
    logic [31:0] pv;
    pv = ext_pin[p*32 +: 32];
    return (m_sens[p] & ~(pv ^ m_pol[p])) | (~m_sens[p] & m_lat[p]) | m_soft[p];
  endfunction

  function automatic logic exp_irq();
    logic r;
    r = 1'b0;
    for (int p = 0; p < NP; p++) r |= |(exp_stat(p) & ~m_mask[p] & m_dom[p]);
    return r;
  endfunction

  task automatic set_pins(input logic [63:0] v);
    for (int p = 0; p < NP; p++) begin
      logic [31:0] o, n;
      o = ext_pin[p*32 +: 32];
      n = v[p*32 +: 32];
      m_lat[p] |= ~m_sens[p] & ((m_pol[p] & n & ~o) | (~m_pol[p] & ~n & o));
    end
    @(negedge clk);
    ext_pin = v;
    repeat (4) @(negedge clk);
  endtask

  task automatic check_all(input string r);
    logic [31:0] d;
    for (int p = 0; p < NP; p++) begin
      rd(GRP_STAT, p, d); chk({r, " status"}, d, exp_stat(p));
      rd(GRP_MASK, p, d); chk({r, " mask"}, d, m_mask[p]);
      rd(GRP_SENS, p, d); chk({r, " sens"}, d, m_sens[p]);
      rd(GRP_POL,  p, d); chk({r, " pol"},  d, m_pol[p]);
      rd(GRP_SOFT, p, d); chk({r, " soft"}, d, m_soft[p]);
      rd(GRP_DOM,  p, d); chk({r, " dom"},  d, m_dom[p]);
    end
    chk({r, " irq"}, 32'(irq_out), 32'(exp_irq()));
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog act=running exp=finished");
    finish_run();
  end

  initial begin
    logic [31:0] d, pat;
    rst_n = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0; ext_pin = '0;
    for (int p = 0; p < NP; p++) begin
      m_mask[p] = '1; m_sens[p] = '0; m_pol[p] = '0;
      m_soft[p] = '0; m_dom[p] = '0; m_lat[p] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    check_all("R1");
    // R2 write-only groups read zero
    rd(GRP_ACK, 0, d);      chk("R2 ack reads 0", d, 32'h0);
    rd(GRP_MASK_SET, 1, d); chk("R2 mask-set reads 0", d, 32'h0);
    rd(GRP_POL_CLR, 0, d);  chk("R2 pol-clr reads 0", d, 32'h0);

    // R3 mask aliases, read view write ignored
    for (int p = 0; p < NP; p++) begin
      for (int k = 0; k < 4; k++) begin
        pat = 32'h9E3779B9 * (k + 1) + p;
        do_wr(GRP_MASK_CLR, p, pat);
        do_wr(GRP_MASK_SET, p, pat >> (k + 1));
        do_wr(GRP_MASK, p, 32'h0);
        check_all("R3");
      end
    end

    // R4 sensitivity, polarity, soft aliases
    for (int p = 0; p < NP; p++) begin
      for (int k = 0; k < 3; k++) begin
        pat = 32'h7F4A7C15 * (k + 3) ^ p;
        do_wr(GRP_SENS_SET, p, pat);
        do_wr(GRP_SENS_CLR, p, pat << 2);
        do_wr(GRP_POL_SET, p, ~pat);
        do_wr(GRP_POL_CLR, p, pat & 32'h00FF00FF);
        do_wr(GRP_SOFT_SET, p, pat ^ 32'hA5A5A5A5);
        do_wr(GRP_SOFT_CLR, p, pat);
        do_wr(GRP_SENS, p, 32'hFFFFFFFF);
        do_wr(GRP_POL, p, 32'hFFFFFFFF);
        do_wr(GRP_SOFT, p, 32'hFFFFFFFF);
        check_all("R4");
      end
    end

    // clean up
    for (int p = 0; p < NP; p++) begin
      do_wr(GRP_SOFT_CLR, p, '1);
      do_wr(GRP_SENS_CLR, p, '1);
      do_wr(GRP_POL_CLR, p, '1);
      do_wr(GRP_ACK, p, '1);
    end

    // R5 edge detection over pin sequences
    do_wr(GRP_POL_SET, 0, 32'hAAAA5555);
    do_wr(GRP_POL_SET, 1, 32'h0F0F0F0F);
    for (int i = 0; i < 8; i++) begin
      set_pins({32'(i) * 32'h6D2B79F5, ~(32'(i) * 32'h1F123BB5)});
      check_all("R5");
    end
    // R6 ack
    do_wr(GRP_ACK, 0, 32'h0);
    check_all("R6 zero ack");
    do_wr(GRP_ACK, 0, 32'hFFFF0000);
    do_wr(GRP_ACK, 1, 32'h3C3C3C3C);
    check_all("R6 partial ack");
    do_wr(GRP_ACK, 0, '1);
    do_wr(GRP_ACK, 1, '1);
    check_all("R6 full ack");

    // R7 level mode
    do_wr(GRP_SENS_SET, 0, '1);
    do_wr(GRP_SENS_SET, 1, '1);
    for (int i = 0; i < 6; i++) begin
      set_pins({32'(i) * 32'h2545F491, 32'(i + 7) * 32'h4F1BBCDD});
      check_all("R7");
    end

    // R11 polarity change with steady pins
    do_wr(GRP_SENS_CLR, 0, '1);
    do_wr(GRP_SENS_CLR, 1, '1);
    set_pins(64'h00FF00FF_F0F0F0F0);
    do_wr(GRP_ACK, 0, '1);
    do_wr(GRP_ACK, 1, '1);
    do_wr(GRP_POL_SET, 0, '1);
    do_wr(GRP_POL_SET, 1, '1);
    check_all("R11 pol up");
    do_wr(GRP_POL_CLR, 0, '1);
    do_wr(GRP_POL_CLR, 1, '1);
    check_all("R11 pol down");

    // R2 R8 R9 R10 every line
    set_pins(64'h0);
    for (int p = 0; p < NP; p++) begin
      do_wr(GRP_POL_SET, p, '1);
      do_wr(GRP_ACK, p, '1);
      do_wr(GRP_MASK_CLR, p, '1);
      do_wr(GRP_DOM, p, '0);
    end
    for (int n = 0; n < 64; n++) begin
      int p;
      logic [31:0] b;
      p = n / 32;
      b = 32'h1 << (n % 32);
      do_wr(GRP_SOFT_SET, p, b);
      chk("R10 no domain", 32'(irq_out), 32'h0);
      do_wr(GRP_DOM, p, b);
      chk("R9 line reaches irq", 32'(irq_out), 32'h1);
      rd(GRP_STAT, p, d);
      chk("R2 line bit position", d, b);
      do_wr(GRP_MASK_SET, p, b);
      chk("R9 masked line", 32'(irq_out), 32'h0);
      do_wr(GRP_MASK_CLR, p, b);
      do_wr(GRP_DOM, p, ~b);
      chk("R9 domain bit off", 32'(irq_out), 32'h0);
      do_wr(GRP_DOM, p, b);
      do_wr(GRP_ACK, p, b);
      chk("R8 ack keeps soft", 32'(irq_out), 32'h1);
      do_wr(GRP_SOFT_CLR, p, b);
      chk("R8 soft cleared", 32'(irq_out), 32'h0);
      do_wr(GRP_DOM, p, 32'h0);
    end

    // R12 two-edge latency, line 37
    do_wr(GRP_SENS_SET, 1, 32'h20);
    do_wr(GRP_DOM, 1, 32'h20);
    check_all("R12 setup");
    @(negedge clk);
    ext_pin[37] = 1'b1;
    @(negedge clk);
    chk("R12 after one edge", 32'(irq_out), 32'h0);
    @(negedge clk);
    chk("R12 after two edges", 32'(irq_out), 32'h1);
    set_pins(64'h0);
    check_all("R12 released");

    finish_run();
  end
endmodule